// File: doc/BRIEF.md
# Boundary-Scan Chain Control Strobe Generator

This block sits beside a test access port controller and derives the control strobes that an external boundary-scan cell chain needs. It takes the TAP controller's current state as a 4-bit code, the instruction value being loaded and the scan-chain number being selected. It keeps its own copies of the active instruction and of the selected chain, and from them it produces the following outputs:

- capture strobes for the external-test and internal-test instructions;
- an update strobe;
- two gated shift clocks;
- a cell-multiplexer drive select;
- a reset indication;
- a high-impedance flag;
- a data-bus disable flag.

A strobe reaches the chain only when the TAP state, the active instruction and the selected chain all agree. The boundary-scan chain is chain number 3.

The block runs entirely on a fast system clock. A free-running divider splits each test-clock period of `TCK_DIV` system cycles into a high half and a low half. Inside the high half it forms a phase-1 window, and inside the low half a phase-2 window. The two windows never overlap, and each edge of the test clock is guarded by a one-cycle gap. Every output is a flop, so the outputs are glitch-free and can be checked cycle by cycle. The TAP state, instruction and chain inputs are held steady for one whole test-clock period. Updates that depend on the TAP state take effect at the falling point of the test clock.

Top module: `bscan_ctrl`

## Requirements
- R1: Number the system clock edges 1, 2, 3 and so on, starting from the first edge after `rst_n` rises. Edge n carries phase position c = (n-1) mod `TCK_DIV`, and every output changes at an edge according to the inputs sampled at that edge. With H = `TCK_DIV`/2, `tck_ph1_o` is 1 after edges with 1 <= c <= H-1. `tck_ph2_o` is 1 after edges with H+1 <= c <= `TCK_DIV`-1. The edge with c = H is the falling point.
- R2: `ecap_o` is 1 exactly when all of the following hold: `tck_ph2_o` is 1, the state is capture-DR (code 6), the active instruction is external test (code 0) and the active chain is 3.
- R3: `icap_o` obeys the same rule as R2, except that the active instruction is internal test (code 12).
- R4: `upd_o` is 1 exactly when `tck_ph2_o` is 1, the state is update-DR (code 5) and the active chain is 3, whatever the instruction. The active chain here includes a chain number latched at the falling point of that same update-DR period.
- R5: In shift-DR (code 2) with active chain 3, `sh1_o` equals `tck_ph1_o` and `sh2_o` equals `tck_ph2_o`. In every other case both are 0.
- R6: At the falling point in update-IR (code 13), `ir_o` takes `ir_in`. In any other state it holds its value.
- R7: At the falling point in update-DR, `chain_o` takes `chain_in`. In any other state it holds its value.
- R8: At the falling point in update-IR, `drive_o` becomes 1 when two conditions hold: the chain active before that edge is 3, and `ir_in` is internal test (12), external test (0), clamp (5) or clamp-to-high-impedance (9). Otherwise it becomes 0. It changes at no other time.
- R9: `rst_ind_o` is 1 after every edge at which the state was test-logic-reset (code 15) or `trst_n` was 0. After every other edge it is 0.
- R10: `highz_o` is 1 exactly while `ir_o` holds the high-impedance instruction (code 7).
- R11: `busdis_o` is 1 exactly while `ir_o` is internal test and `chain_o` is 0 or 4, so it changes only at the same edge as the mirrors.
- R12: While `rst_n` is 0, every strobe is 0 and so are `tck_ph1_o`, `tck_ph2_o`, `drive_o`, `rst_ind_o`, `highz_o` and `busdis_o`. In that condition `ir_o` is 14 (identify) and `chain_o` is 0. After every edge with `trst_n` at 0, `ir_o` is 14, `chain_o` is 0 and `drive_o` is 0.
- R13: At the falling point in test-logic-reset, `ir_o` returns to 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the test clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| trst_n | input | 1 | Active-low test reset |
| tap_state_i | input | 4 | Current TAP controller state code |
| ir_in | input | 4 | Instruction value presented for loading |
| chain_in | input | 4 | Scan-chain number presented for selection |
| tck_ph1_o | output | 1 | Phase-1 window of the test clock |
| tck_ph2_o | output | 1 | Phase-2 window of the test clock |
| ecap_o | output | 1 | External-test capture strobe |
| icap_o | output | 1 | Internal-test capture strobe |
| upd_o | output | 1 | Update strobe for the external chain |
| sh1_o | output | 1 | Gated phase-1 shift clock |
| sh2_o | output | 1 | Gated phase-2 shift clock |
| drive_o | output | 1 | Cell multiplexer drive select |
| rst_ind_o | output | 1 | Boundary-scan reset indication |
| highz_o | output | 1 | High-impedance instruction active |
| busdis_o | output | 1 | Data-bus disable for internal test on chain 0 or 4 |
| ir_o | output | 4 | Active instruction mirror |
| chain_o | output | 4 | Active scan-chain mirror |

## Verification
In an update-DR period, the chain-number update at the falling point coincides with the qualification of the update strobe. The bench loads chain 3 through update-DR while the previous chain was something else, and it expects the strobe to fire in the phase-2 half of that same period. In an update-IR period, the instruction update and the drive-select decision land on the same edge. There the bench expects drive select to use the chain active before the edge together with the incoming instruction. A further period holds the test reset low while the mirrors would otherwise update, and the bench expects the reset values to win from the first edge.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    // IEEE 1149.1 TAP state codes
    localparam logic [3:0] TAP_TLR     = 4'hF;
    localparam logic [3:0] TAP_RTI     = 4'hC;
    localparam logic [3:0] TAP_SEL_DR  = 4'h7;
    localparam logic [3:0] TAP_CAP_DR  = 4'h6;
    localparam logic [3:0] TAP_SH_DR   = 4'h2;
    localparam logic [3:0] TAP_EX1_DR  = 4'h1;
    localparam logic [3:0] TAP_PAU_DR  = 4'h3;
    localparam logic [3:0] TAP_EX2_DR  = 4'h0;
    localparam logic [3:0] TAP_UPD_DR  = 4'h5;
    localparam logic [3:0] TAP_SEL_IR  = 4'h4;
    localparam logic [3:0] TAP_CAP_IR  = 4'hE;
    localparam logic [3:0] TAP_SH_IR   = 4'hA;
    localparam logic [3:0] TAP_EX1_IR  = 4'h9;
    localparam logic [3:0] TAP_PAU_IR  = 4'hB;
    localparam logic [3:0] TAP_EX2_IR  = 4'h8;
    localparam logic [3:0] TAP_UPD_IR  = 4'hD;

    // instruction codes
    localparam logic [3:0] INS_EXTEST  = 4'h0;
    localparam logic [3:0] INS_SCANSEL = 4'h2;
    localparam logic [3:0] INS_CLAMP   = 4'h5;
    localparam logic [3:0] INS_HIGHZ   = 4'h7;
    localparam logic [3:0] INS_CLAMPZ  = 4'h9;
    localparam logic [3:0] INS_INTEST  = 4'hC;
    localparam logic [3:0] INS_IDENT   = 4'hE;
    localparam logic [3:0] INS_BYPASS  = 4'hF;

    // registered single-bit outputs of the top level
    typedef struct packed {
        logic ph1;
        logic ph2;
        logic ecap;
        logic icap;
        logic upd;
        logic sh1;
        logic sh2;
        logic rst_ind;
        logic highz;
        logic busdis;
    } bscan_flags_t;

endpackage

// File: rtl/bscan_phase_gen.sv
module bscan_phase_gen #(
    parameter int TCK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic ph1,
    output logic ph2,
    output logic fall_pt
);
    localparam int HALF = TCK_DIV / 2;
    localparam int CW   = (TCK_DIV > 2) ? $clog2(TCK_DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == CW'(TCK_DIV - 1)) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // gap slots at position 0 (rise) and HALF (fall) keep phases apart
    assign ph1     = (cnt_q >= CW'(1)) && (cnt_q <= CW'(HALF - 1));
    assign ph2     = (cnt_q >= CW'(HALF + 1));
    assign fall_pt = (cnt_q == CW'(HALF));

endmodule

// File: rtl/bscan_decode.sv
module bscan_decode #(
    parameter int ST_W = 4,
    parameter int IR_W = 4,
    parameter int CH_W = 4,
    parameter logic [ST_W-1:0] S_TLR    = bscan_pkg::TAP_TLR,
    parameter logic [ST_W-1:0] S_CAP_DR = bscan_pkg::TAP_CAP_DR,
    parameter logic [ST_W-1:0] S_SH_DR  = bscan_pkg::TAP_SH_DR,
    parameter logic [ST_W-1:0] S_UPD_DR = bscan_pkg::TAP_UPD_DR,
    parameter logic [ST_W-1:0] S_UPD_IR = bscan_pkg::TAP_UPD_IR,
    parameter logic [IR_W-1:0] I_EXTEST = bscan_pkg::INS_EXTEST,
    parameter logic [IR_W-1:0] I_INTEST = bscan_pkg::INS_INTEST,
    parameter logic [IR_W-1:0] I_CLAMP  = bscan_pkg::INS_CLAMP,
    parameter logic [IR_W-1:0] I_CLAMPZ = bscan_pkg::INS_CLAMPZ,
    parameter logic [IR_W-1:0] I_HIGHZ  = bscan_pkg::INS_HIGHZ,
    parameter int BS_CHAIN   = 3,
    parameter int BD_CHAIN_A = 0,
    parameter int BD_CHAIN_B = 4
) (
    input  logic [ST_W-1:0] state,
    input  logic [IR_W-1:0] ir_cur,
    input  logic [IR_W-1:0] ir_nxt,
    input  logic [IR_W-1:0] ir_new,
    input  logic [CH_W-1:0] chain_cur,
    input  logic [CH_W-1:0] chain_nxt,
    output logic            st_cap_dr,
    output logic            st_sh_dr,
    output logic            st_upd_dr,
    output logic            st_upd_ir,
    output logic            st_tlr,
    output logic            cur_extest,
    output logic            cur_intest,
    output logic            cur_bs_chain,
    output logic            new_drive_grp,
    output logic            nxt_highz,
    output logic            nxt_busdis
);
    always_comb begin
        st_cap_dr     = (state == S_CAP_DR);
        st_sh_dr      = (state == S_SH_DR);
        st_upd_dr     = (state == S_UPD_DR);
        st_upd_ir     = (state == S_UPD_IR);
        st_tlr        = (state == S_TLR);
        cur_extest    = (ir_cur == I_EXTEST);
        cur_intest    = (ir_cur == I_INTEST);
        cur_bs_chain  = (chain_cur == CH_W'(BS_CHAIN));
        new_drive_grp = (ir_new == I_INTEST) || (ir_new == I_EXTEST) ||
                        (ir_new == I_CLAMP)  || (ir_new == I_CLAMPZ);
        nxt_highz     = (ir_nxt == I_HIGHZ);
        nxt_busdis    = (ir_nxt == I_INTEST) &&
                        ((chain_nxt == CH_W'(BD_CHAIN_A)) ||
                         (chain_nxt == CH_W'(BD_CHAIN_B)));
    end

endmodule

// File: rtl/bscan_mirror.sv
module bscan_mirror #(
    parameter int IR_W = 4,
    parameter int CH_W = 4,
    parameter logic [IR_W-1:0] IR_RESET = bscan_pkg::INS_IDENT,
    parameter logic [CH_W-1:0] CH_RESET = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trst_n,
    input  logic            fall_pt,
    input  logic            st_upd_ir,
    input  logic            st_upd_dr,
    input  logic            st_tlr,
    input  logic [IR_W-1:0] ir_new,
    input  logic [CH_W-1:0] chain_new,
    input  logic            drive_new,
    output logic [IR_W-1:0] ir_d,
    output logic [IR_W-1:0] ir_q,
    output logic [CH_W-1:0] chain_d,
    output logic [CH_W-1:0] chain_q,
    output logic            drive_q
);
    typedef struct packed {
        logic [IR_W-1:0] ir;
        logic [CH_W-1:0] chain;
        logic            drive;
    } mir_t;

    mir_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (!trst_n) begin
            m_d.ir    = IR_RESET;
            m_d.chain = CH_RESET;
            m_d.drive = 1'b0;
        end else if (fall_pt) begin
            if (st_tlr) begin
                m_d.ir = IR_RESET;
            end else if (st_upd_ir) begin
                m_d.ir    = ir_new;
                m_d.drive = drive_new;
            end
            if (st_upd_dr) begin
                m_d.chain = chain_new;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q.ir    <= IR_RESET;
            m_q.chain <= CH_RESET;
            m_q.drive <= 1'b0;
        end else begin
            m_q <= m_d;
        end
    end

    assign ir_d    = m_d.ir;
    assign ir_q    = m_q.ir;
    assign chain_d = m_d.chain;
    assign chain_q = m_q.chain;
    assign drive_q = m_q.drive;

endmodule

// File: rtl/bscan_ctrl.sv
module bscan_ctrl #(
    parameter int TCK_DIV = 8,
    parameter int ST_W    = 4,
    parameter int IR_W    = 4,
    parameter int CH_W    = 4,
    parameter logic [ST_W-1:0] S_TLR    = bscan_pkg::TAP_TLR,
    parameter logic [ST_W-1:0] S_CAP_DR = bscan_pkg::TAP_CAP_DR,
    parameter logic [ST_W-1:0] S_SH_DR  = bscan_pkg::TAP_SH_DR,
    parameter logic [ST_W-1:0] S_UPD_DR = bscan_pkg::TAP_UPD_DR,
    parameter logic [ST_W-1:0] S_UPD_IR = bscan_pkg::TAP_UPD_IR,
    parameter logic [IR_W-1:0] I_EXTEST = bscan_pkg::INS_EXTEST,
    parameter logic [IR_W-1:0] I_INTEST = bscan_pkg::INS_INTEST,
    parameter logic [IR_W-1:0] I_CLAMP  = bscan_pkg::INS_CLAMP,
    parameter logic [IR_W-1:0] I_CLAMPZ = bscan_pkg::INS_CLAMPZ,
    parameter logic [IR_W-1:0] I_HIGHZ  = bscan_pkg::INS_HIGHZ,
    parameter logic [IR_W-1:0] IR_RESET = bscan_pkg::INS_IDENT,
    parameter int BS_CHAIN   = 3,
    parameter int BD_CHAIN_A = 0,
    parameter int BD_CHAIN_B = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trst_n,
    input  logic [ST_W-1:0] tap_state_i,
    input  logic [IR_W-1:0] ir_in,
    input  logic [CH_W-1:0] chain_in,
    output logic            tck_ph1_o,
    output logic            tck_ph2_o,
    output logic            ecap_o,
    output logic            icap_o,
    output logic            upd_o,
    output logic            sh1_o,
    output logic            sh2_o,
    output logic            drive_o,
    output logic            rst_ind_o,
    output logic            highz_o,
    output logic            busdis_o,
    output logic [IR_W-1:0] ir_o,
    output logic [CH_W-1:0] chain_o
);
    import bscan_pkg::*;

    logic ph1, ph2, fall_pt;
    logic st_cap_dr, st_sh_dr, st_upd_dr, st_upd_ir, st_tlr;
    logic cur_extest, cur_intest, cur_bs_chain, new_drive_grp;
    logic nxt_highz, nxt_busdis;
    logic [IR_W-1:0] ir_d, ir_q;
    logic [CH_W-1:0] chain_d, chain_q;
    logic drive_q;

    bscan_flags_t fl_d, fl_q;

    bscan_phase_gen #(
        .TCK_DIV (TCK_DIV)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .ph1     (ph1),
        .ph2     (ph2),
        .fall_pt (fall_pt)
    );

    bscan_decode #(
        .ST_W (ST_W), .IR_W (IR_W), .CH_W (CH_W),
        .S_TLR (S_TLR), .S_CAP_DR (S_CAP_DR), .S_SH_DR (S_SH_DR),
        .S_UPD_DR (S_UPD_DR), .S_UPD_IR (S_UPD_IR),
        .I_EXTEST (I_EXTEST), .I_INTEST (I_INTEST), .I_CLAMP (I_CLAMP),
        .I_CLAMPZ (I_CLAMPZ), .I_HIGHZ (I_HIGHZ),
        .BS_CHAIN (BS_CHAIN), .BD_CHAIN_A (BD_CHAIN_A), .BD_CHAIN_B (BD_CHAIN_B)
    ) u_dec (
        .state         (tap_state_i),
        .ir_cur        (ir_q),
        .ir_nxt        (ir_d),
        .ir_new        (ir_in),
        .chain_cur     (chain_q),
        .chain_nxt     (chain_d),
        .st_cap_dr     (st_cap_dr),
        .st_sh_dr      (st_sh_dr),
        .st_upd_dr     (st_upd_dr),
        .st_upd_ir     (st_upd_ir),
        .st_tlr        (st_tlr),
        .cur_extest    (cur_extest),
        .cur_intest    (cur_intest),
        .cur_bs_chain  (cur_bs_chain),
        .new_drive_grp (new_drive_grp),
        .nxt_highz     (nxt_highz),
        .nxt_busdis    (nxt_busdis)
    );

    bscan_mirror #(
        .IR_W (IR_W), .CH_W (CH_W), .IR_RESET (IR_RESET), .CH_RESET ('0)
    ) u_mir (
        .clk       (clk),
        .rst_n     (rst_n),
        .trst_n    (trst_n),
        .fall_pt   (fall_pt),
        .st_upd_ir (st_upd_ir),
        .st_upd_dr (st_upd_dr),
        .st_tlr    (st_tlr),
        .ir_new    (ir_in),
        .chain_new (chain_in),
        .drive_new (new_drive_grp && cur_bs_chain),
        .ir_d      (ir_d),
        .ir_q      (ir_q),
        .chain_d   (chain_d),
        .chain_q   (chain_q),
        .drive_q   (drive_q)
    );

    always_comb begin
        fl_d         = '0;
        fl_d.ph1     = ph1;
        fl_d.ph2     = ph2;
        fl_d.ecap    = ph2 && st_cap_dr && cur_extest && cur_bs_chain;
        fl_d.icap    = ph2 && st_cap_dr && cur_intest && cur_bs_chain;
        fl_d.upd     = ph2 && st_upd_dr && cur_bs_chain;
        fl_d.sh1     = ph1 && st_sh_dr && cur_bs_chain;
        fl_d.sh2     = ph2 && st_sh_dr && cur_bs_chain;
        fl_d.rst_ind = st_tlr || !trst_n;
        fl_d.highz   = nxt_highz;
        fl_d.busdis  = nxt_busdis;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign tck_ph1_o = fl_q.ph1;
    assign tck_ph2_o = fl_q.ph2;
    assign ecap_o    = fl_q.ecap;
    assign icap_o    = fl_q.icap;
    assign upd_o     = fl_q.upd;
    assign sh1_o     = fl_q.sh1;
    assign sh2_o     = fl_q.sh2;
    assign rst_ind_o = fl_q.rst_ind;
    assign highz_o   = fl_q.highz;
    assign busdis_o  = fl_q.busdis;
    assign drive_o   = drive_q;
    assign ir_o      = ir_q;
    assign chain_o   = chain_q;

endmodule

// File: rtl/bscan_ctrl_chk.sv
module bscan_ctrl_chk #(
    parameter int ST_W = 4,
    parameter int IR_W = 4,
    parameter int CH_W = 4,
    parameter logic [ST_W-1:0] S_TLR    = bscan_pkg::TAP_TLR,
    parameter logic [ST_W-1:0] S_UPD_DR = bscan_pkg::TAP_UPD_DR,
    parameter logic [ST_W-1:0] S_UPD_IR = bscan_pkg::TAP_UPD_IR,
    parameter logic [IR_W-1:0] I_INTEST = bscan_pkg::INS_INTEST,
    parameter logic [IR_W-1:0] I_HIGHZ  = bscan_pkg::INS_HIGHZ,
    parameter int BD_CHAIN_A = 0,
    parameter int BD_CHAIN_B = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trst_n,
    input logic [ST_W-1:0] tap_state_i,
    input logic            tck_ph1_o,
    input logic            tck_ph2_o,
    input logic            ecap_o,
    input logic            icap_o,
    input logic            upd_o,
    input logic            sh1_o,
    input logic            sh2_o,
    input logic            rst_ind_o,
    input logic            highz_o,
    input logic            busdis_o,
    input logic [IR_W-1:0] ir_o,
    input logic [CH_W-1:0] chain_o
);
    a_r1_phases_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(tck_ph1_o && tck_ph2_o));

    a_r2_ecap_in_ph2: assert property (@(posedge clk) disable iff (!rst_n)
        ecap_o |-> tck_ph2_o);

    a_r3_caps_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ecap_o && icap_o));

    a_r4_upd_in_ph2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> tck_ph2_o);

    a_r5_sh1_in_ph1: assert property (@(posedge clk) disable iff (!rst_n)
        sh1_o |-> tck_ph1_o);

    a_r5_sh2_in_ph2: assert property (@(posedge clk) disable iff (!rst_n)
        sh2_o |-> tck_ph2_o);

    a_r6_ir_change_src: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ir_o) |-> ($past(tap_state_i) == S_UPD_IR ||
                            $past(tap_state_i) == S_TLR || !$past(trst_n)));

    a_r7_chain_change_src: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chain_o) |-> ($past(tap_state_i) == S_UPD_DR || !$past(trst_n)));

    a_r9_rst_ind: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_state_i == S_TLR || !trst_n) |=> rst_ind_o);

    a_r10_highz_tracks_ir: assert property (@(posedge clk) disable iff (!rst_n)
        highz_o == (ir_o == I_HIGHZ));

    a_r11_busdis_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        busdis_o == ((ir_o == I_INTEST) &&
                     (chain_o == CH_W'(BD_CHAIN_A) || chain_o == CH_W'(BD_CHAIN_B))));

endmodule

bind bscan_ctrl bscan_ctrl_chk #(
    .ST_W (ST_W), .IR_W (IR_W), .CH_W (CH_W),
    .S_TLR (S_TLR), .S_UPD_DR (S_UPD_DR), .S_UPD_IR (S_UPD_IR),
    .I_INTEST (I_INTEST), .I_HIGHZ (I_HIGHZ),
    .BD_CHAIN_A (BD_CHAIN_A), .BD_CHAIN_B (BD_CHAIN_B)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trst_n      (trst_n),
    .tap_state_i (tap_state_i),
    .tck_ph1_o   (tck_ph1_o),
    .tck_ph2_o   (tck_ph2_o),
    .ecap_o      (ecap_o),
    .icap_o      (icap_o),
    .upd_o       (upd_o),
    .sh1_o       (sh1_o),
    .sh2_o       (sh2_o),
    .rst_ind_o   (rst_ind_o),
    .highz_o     (highz_o),
    .busdis_o    (busdis_o),
    .ir_o        (ir_o),
    .chain_o     (chain_o)
);

// File: tb/sim_bscan_ctrl.sv
`timescale 1ns/1ps
module sim_bscan_ctrl;
    import bscan_pkg::*;

    localparam int P = 8;
    localparam int H = P / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trst_n = 1'b1;
    logic [3:0] tap_state = TAP_RTI;
    logic [3:0] ir_in = 4'h0;
    logic [3:0] chain_in = 4'h0;
    logic tck_ph1, tck_ph2, ecap, icap, upd, sh1, sh2, drive, rst_ind, highz, busdis;
    logic [3:0] ir_o, chain_o;

    int total = 0;
    int bad = 0;
    int bcnt = 0;

    always #4 clk = ~clk;

    bscan_ctrl #(.TCK_DIV(P)) u0 (
        .clk (clk), .rst_n (rst_n), .trst_n (trst_n),
        .tap_state_i (tap_state), .ir_in (ir_in), .chain_in (chain_in),
        .tck_ph1_o (tck_ph1), .tck_ph2_o (tck_ph2),
        .ecap_o (ecap), .icap_o (icap), .upd_o (upd),
        .sh1_o (sh1), .sh2_o (sh2), .drive_o (drive),
        .rst_ind_o (rst_ind), .highz_o (highz), .busdis_o (busdis),
        .ir_o (ir_o), .chain_o (chain_o)
    );

    // bench's own position in the test-clock period (R1)
    always @(posedge clk) begin
        if (!rst_n) bcnt <= 0;
        else        bcnt <= (bcnt == P - 1) ? 0 : bcnt + 1;
    end

    typedef struct packed {
        logic [3:0] st;
        logic       tr;
        logic       ph1, ph2, ecap, icap, upd, sh1, sh2, drive, rsti, hz, bd;
        logic [3:0] ir, ch;
    } exp_t;

    exp_t sb[$];

    // bench-side model of the mirrors
    logic [3:0] m_ir = INS_IDENT;
    logic [3:0] m_ch = 4'h0;
    logic       m_dr = 1'b0;

    task automatic chk(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // driver: one test-clock period with held inputs, pushes per-cycle expectations
    task automatic tperiod(input logic [3:0] s, input logic [3:0] irn, input logic [3:0] chn, input logic tr);
        exp_t e;
        logic [3:0] pir, pch;
        logic grp;
        @(negedge clk);
        while (bcnt != 0) @(negedge clk);
        tap_state = s; ir_in = irn; chain_in = chn; trst_n = tr;
        grp = (irn == INS_INTEST) || (irn == INS_EXTEST) || (irn == INS_CLAMP) || (irn == INS_CLAMPZ);
        for (int c = 0; c < P; c++) begin
            pir = m_ir; pch = m_ch;
            if (!tr) begin
                m_ir = INS_IDENT; m_ch = 4'h0; m_dr = 1'b0;
            end else if (c == H) begin
                if (s == TAP_TLR) m_ir = INS_IDENT;
                else if (s == TAP_UPD_IR) begin
                    m_dr = (pch == 4'd3) && grp;
                    m_ir = irn;
                end
                if (s == TAP_UPD_DR) m_ch = chn;
            end
            e.st   = s;
            e.tr   = tr;
            e.ph1  = (c >= 1) && (c <= H - 1);
            e.ph2  = (c >= H + 1);
            e.ecap = e.ph2 && (s == TAP_CAP_DR) && (pir == INS_EXTEST) && (pch == 4'd3);
            e.icap = e.ph2 && (s == TAP_CAP_DR) && (pir == INS_INTEST) && (pch == 4'd3);
            e.upd  = e.ph2 && (s == TAP_UPD_DR) && (pch == 4'd3);
            e.sh1  = e.ph1 && (s == TAP_SH_DR) && (pch == 4'd3);
            e.sh2  = e.ph2 && (s == TAP_SH_DR) && (pch == 4'd3);
            e.drive = m_dr;
            e.rsti = (s == TAP_TLR) || !tr;
            e.hz   = (m_ir == INS_HIGHZ);
            e.bd   = (m_ir == INS_INTEST) && ((m_ch == 4'd0) || (m_ch == 4'd4));
            e.ir   = m_ir;
            e.ch   = m_ch;
            sb.push_back(e);
        end
    endtask

    // monitor: compares one expectation per system clock
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                chk("R1", "tck_ph1", {3'b0, tck_ph1}, {3'b0, e.ph1});
                chk("R1", "tck_ph2", {3'b0, tck_ph2}, {3'b0, e.ph2});
                chk("R2", "ecap", {3'b0, ecap}, {3'b0, e.ecap});
                chk("R3", "icap", {3'b0, icap}, {3'b0, e.icap});
                chk("R4", "upd", {3'b0, upd}, {3'b0, e.upd});
                chk("R5", "sh1", {3'b0, sh1}, {3'b0, e.sh1});
                chk("R5", "sh2", {3'b0, sh2}, {3'b0, e.sh2});
                chk(!e.tr ? "R12" : "R8", "drive", {3'b0, drive}, {3'b0, e.drive});
                chk("R9", "rst_ind", {3'b0, rst_ind}, {3'b0, e.rsti});
                chk("R10", "highz", {3'b0, highz}, {3'b0, e.hz});
                chk("R11", "busdis", {3'b0, busdis}, {3'b0, e.bd});
                chk(!e.tr ? "R12" : ((e.st == TAP_TLR) ? "R13" : "R6"), "ir", ir_o, e.ir);
                chk(!e.tr ? "R12" : "R7", "chain", chain_o, e.ch);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        chk("R12", "flags", {tck_ph1, tck_ph2, ecap, icap}, 4'h0);
        chk("R12", "strobes", {upd, sh1, sh2, drive}, 4'h0);
        chk("R12", "ind", {1'b0, rst_ind, highz, busdis}, 4'h0);
        chk("R12", "ir", ir_o, INS_IDENT);
        chk("R12", "chain", chain_o, 4'h0);
        rst_n = 1'b1;

        tperiod(TAP_RTI, 4'h0, 4'h0, 1'b1);
        tperiod(TAP_UPD_IR, INS_SCANSEL, 4'h0, 1'b1);     // R6, R8 drive stays 0 on chain 0
        tperiod(TAP_UPD_DR, 4'h0, 4'd3, 1'b1);            // R4, R7 same-period chain load
        tperiod(TAP_UPD_IR, INS_EXTEST, 4'd7, 1'b1);      // R8 drive set, chain_in ignored
        tperiod(TAP_CAP_DR, 4'h0, 4'h0, 1'b1);            // R2
        tperiod(TAP_SH_DR, 4'h0, 4'h0, 1'b1);             // R5
        tperiod(TAP_SH_DR, 4'h0, 4'h0, 1'b1);
        tperiod(TAP_UPD_DR, 4'h0, 4'd3, 1'b1);            // R4
        tperiod(TAP_UPD_IR, INS_INTEST, 4'h0, 1'b1);      // R8
        tperiod(TAP_CAP_DR, 4'h0, 4'h0, 1'b1);            // R3
        tperiod(TAP_UPD_IR, INS_CLAMP, 4'h0, 1'b1);
        tperiod(TAP_UPD_IR, INS_BYPASS, 4'h0, 1'b1);      // R8 cleared
        tperiod(TAP_UPD_IR, INS_CLAMPZ, 4'h0, 1'b1);
        tperiod(TAP_UPD_IR, INS_HIGHZ, 4'h0, 1'b1);       // R10
        tperiod(TAP_RTI, INS_EXTEST, 4'd9, 1'b1);         // R6/R7 ignored outside update
        tperiod(TAP_UPD_IR, INS_INTEST, 4'h0, 1'b1);
        tperiod(TAP_UPD_DR, 4'h0, 4'd0, 1'b1);            // R11 busdis on chain 0
        tperiod(TAP_CAP_DR, 4'h0, 4'h0, 1'b1);            // R3 no capture off chain 3
        tperiod(TAP_SH_DR, 4'h0, 4'h0, 1'b1);             // R5 gated off
        tperiod(TAP_UPD_DR, 4'h0, 4'd4, 1'b1);            // R11 chain 4
        tperiod(TAP_UPD_IR, INS_EXTEST, 4'h0, 1'b1);      // R8 not chain 3
        tperiod(TAP_UPD_DR, 4'h0, 4'd3, 1'b1);
        tperiod(TAP_TLR, 4'h0, 4'h0, 1'b1);               // R9, R13
        tperiod(TAP_UPD_IR, INS_EXTEST, 4'h0, 1'b1);
        tperiod(TAP_UPD_IR, INS_HIGHZ, 4'h0, 1'b0);       // R12 test reset wins
        tperiod(TAP_RTI, 4'h0, 4'h0, 1'b1);

        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule